// File: doc/BRIEF.md
# Buffered Frame Transmit Sequencer

This block sends one Ethernet frame that software has already placed in a byte-wide packet buffer. Software sets a start pointer and an end pointer, then raises a transmit-request bit. The byte at the start pointer is not frame data. It is a per-frame control byte whose low nibble is passed to the MAC as override flags. The frame bytes that follow, up to and including the end pointer, go out on a valid/ready byte stream. When the MAC reports a result, the sequencer writes a seven-byte status record into the buffer just past the frame. It then drops the request bit and raises a sticky interrupt flag.

The buffer has one memory port, and a DMA engine also uses it. The sequencer does not start while a DMA session owns the port. A DMA start request that arrives while a transmission is requested stays pending until the request bit falls. Software can cancel a frame in flight by clearing the request bit. A cancelled frame is closed like an aborted one and still gets a status record. The buffer holds 2^ADDR_W bytes, and all pointer steps wrap at that size. The MAC serializer, CRC, padding and PHY sit outside this block.

Top module: `pkt_txseq`

## Requirements
- R1: The byte at the start pointer is taken as the control byte and is never streamed. While a frame is in flight, `tx_ctrl` shows its bits [3:0]: bit0 = use overrides, bit1 = CRC, bit2 = pad, bit3 = huge frame. The first streamed byte comes from start+1.
- R2: Frame bytes are streamed in address order up to and including the byte at the end pointer. `tx_last` is high only on that final byte. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R3: After the frame, seven bytes are written at end+1 through end+7, in this order: byte count [7:0], byte count [15:8], flags, the full control byte, the MAC result code, start pointer [7:0], start pointer [15:8]. The flags byte is {4'b0, cancelled, late collision, abort, ok}, with ok in bit 0. The byte count is the number of frame bytes accepted by the MAC.
- R4: All pointer arithmetic (frame bytes and status bytes) wraps modulo the buffer size of 2^ADDR_W bytes.
- R5: When a frame closes, `txrq` falls and `txif` rises at the same clock edge. `tx_abort` then shows whether the frame was aborted by the MAC or cancelled, and `tx_latecol` shows the MAC's late-collision report.
- R6: `txif` stays set until `txif_clr` is pulsed, whatever the enables are. `irq` is high one cycle after `txif`, `tx_ie` and `glb_ie` are all high.
- R7: A `txrq_clr` pulse during a frame cancels it. `tx_valid` drops at that edge, and the status record is written with the cancelled and abort flags set and the MAC code set to 0.
- R8: If a DMA session owns the port when the request is raised, no memory read and no stream output happen until the DMA session ends. The frame then proceeds normally.
- R9: A DMA start request (`dma_req`) made while `txrq` is high does not grant the port. The grant (`dma_busy`) follows once the frame has closed.
- R10: The start and end pointers change only when software writes them. The hardware leaves them unchanged after a transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Load the start pointer from `ptr_wdata` |
| end_wr | input | 1 | Load the end pointer from `ptr_wdata` |
| ptr_wdata | input | ADDR_W | Pointer write data |
| start_ptr | output | ADDR_W | Start pointer register |
| end_ptr | output | ADDR_W | End pointer register |
| txrq_set | input | 1 | Raise the transmit-request bit |
| txrq_clr | input | 1 | Clear the request bit (cancels a frame in flight) |
| txrq | output | 1 | Transmit-request bit |
| txif_clr | input | 1 | Write-1-to-clear for the interrupt flag |
| tx_ie | input | 1 | Transmit interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| txif | output | 1 | Sticky transmit-done flag |
| irq | output | 1 | Interrupt output |
| tx_abort | output | 1 | Last frame aborted or cancelled |
| tx_latecol | output | 1 | Last frame reported a late collision |
| dma_req | input | 1 | DMA start request pulse |
| dma_done | input | 1 | DMA session end pulse |
| dma_busy | output | 1 | DMA session owns the memory port |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | ADDR_W | DMA address |
| dma_wdata | input | 8 | DMA write data |
| dma_rdata | output | 8 | Read data, one cycle after the address |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_last | output | 1 | Byte is at the end pointer |
| tx_ctrl | output | 4 | Override flags from the control byte |
| res_valid | input | 1 | MAC result strobe |
| res_abort | input | 1 | MAC aborted the frame |
| res_latecol | input | 1 | MAC saw a late collision |
| res_code | input | 8 | MAC result code for the status record |

## Verification
A sequencer whose read address has slipped shows it on the very first handshake: the stream carries the control byte, or skips a byte, and `tx_last` lands on the wrong beat. A wrong status-write base or a missed wrap shows only in the buffer contents after the frame closes. The bench reads every status byte back through the DMA port within a few dozen cycles of `txif`. Arbitration faults show within one cycle of the conflicting request, as a grant raised while `txrq` is high or as stream output while a DMA session owns the port.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTRL_RD, S_CTRL_CAP, S_FETCH, S_LOAD, S_SEND, S_RESULT, S_STAT, S_FINISH
  } seq_state_e;

  localparam int STAT_BYTES = 7;
  localparam int FLG_OK     = 0;
  localparam int FLG_ABORT  = 1;
  localparam int FLG_LATE   = 2;
  localparam int FLG_CANCEL = 3;
endpackage

// File: rtl/txseq_ram.sv
module txseq_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/txseq_regs.sv
module txseq_regs #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          end_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          txrq_set,
  input  logic          txrq_clr,
  input  logic          txif_clr,
  input  logic          tx_ie,
  input  logic          glb_ie,
  input  logic          seq_done,
  input  logic          seq_abort,
  input  logic          seq_late,
  output logic [AW-1:0] start_ptr,
  output logic [AW-1:0] end_ptr,
  output logic          txrq,
  output logic          txif,
  output logic          irq,
  output logic          tx_abort,
  output logic          tx_latecol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_ptr  <= '0;
      end_ptr    <= '0;
      txrq       <= 1'b0;
      txif       <= 1'b0;
      irq        <= 1'b0;
      tx_abort   <= 1'b0;
      tx_latecol <= 1'b0;
    end else begin
      if (start_wr) start_ptr <= ptr_wdata;
      if (end_wr)   end_ptr   <= ptr_wdata;
      if (txrq_clr || seq_done) txrq <= 1'b0;
      else if (txrq_set)        txrq <= 1'b1;
      if (seq_done)      txif <= 1'b1;
      else if (txif_clr) txif <= 1'b0;
      irq <= txif && tx_ie && glb_ie;
      if (seq_done) begin
        tx_abort   <= seq_abort;
        tx_latecol <= seq_late;
      end
    end
  end
endmodule

// File: rtl/txseq_arb.sv
module txseq_arb #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_req,
  input  logic          dma_done,
  input  logic          txrq,
  input  logic          seq_idle,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [7:0]    dma_wdata,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [7:0]    seq_wdata,
  output logic          dma_busy,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      dma_busy <= 1'b0;
    end else begin
      if (dma_busy && dma_done) begin
        dma_busy <= 1'b0;
      end else if (pend && !dma_busy && !txrq && seq_idle) begin
        dma_busy <= 1'b1;
        pend     <= 1'b0;
      end
      if (dma_req) pend <= 1'b1;
    end
  end

  always_comb begin
    if (dma_busy) begin
      ram_we    = dma_we;
      ram_addr  = dma_addr;
      ram_wdata = dma_wdata;
    end else begin
      ram_we    = seq_we;
      ram_addr  = seq_addr;
      ram_wdata = seq_wdata;
    end
  end
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
  import txseq_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          hold,
  input  logic          cancel,
  input  logic [AW-1:0] start_ptr,
  input  logic [AW-1:0] end_ptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic [3:0]    tx_ctrl,
  input  logic          res_valid,
  input  logic          res_abort,
  input  logic          res_latecol,
  input  logic [7:0]    res_code,
  output logic          idle,
  output logic          done,
  output logic          abort_o,
  output logic          late_o
);
  localparam int IW = $clog2(STAT_BYTES);

  seq_state_e      st;
  logic [AW-1:0]   rd_ptr, start_q, end_q;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [7:0]      ctrl_q, code_q;
  logic            ab_q, lc_q, cn_q;
  logic            in_flight;
  logic [15:0]     start_ext;
  logic [7:0]      flags;

  assign in_flight = (st == S_CTRL_RD) || (st == S_CTRL_CAP) || (st == S_FETCH) ||
                     (st == S_LOAD) || (st == S_SEND) || (st == S_RESULT);
  assign idle    = (st == S_IDLE);
  assign done    = (st == S_FINISH);
  assign abort_o = ab_q || cn_q;
  assign late_o  = lc_q;
  assign start_ext = 16'(start_q);

  always_comb begin
    flags = '0;
    flags[FLG_OK]     = !(ab_q || cn_q);
    flags[FLG_ABORT]  = ab_q || cn_q;
    flags[FLG_LATE]   = lc_q;
    flags[FLG_CANCEL] = cn_q;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = rd_ptr;
    mem_wdata = '0;
    case (st)
      S_CTRL_RD: mem_addr = start_q;
      S_STAT: begin
        mem_we   = 1'b1;
        mem_addr = end_q + AW'(1) + AW'(idx);
        case (idx)
          IW'(0):  mem_wdata = cnt[7:0];
          IW'(1):  mem_wdata = 8'(cnt >> 8);
          IW'(2):  mem_wdata = flags;
          IW'(3):  mem_wdata = ctrl_q;
          IW'(4):  mem_wdata = code_q;
          IW'(5):  mem_wdata = start_ext[7:0];
          default: mem_wdata = start_ext[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      rd_ptr   <= '0;
      start_q  <= '0;
      end_q    <= '0;
      idx      <= '0;
      cnt      <= '0;
      ctrl_q   <= '0;
      code_q   <= '0;
      ab_q     <= 1'b0;
      lc_q     <= 1'b0;
      cn_q     <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_ctrl  <= '0;
    end else begin
      if (st == S_SEND && tx_valid && tx_ready) cnt <= cnt + CW'(1);
      if (cancel && in_flight) begin
        cn_q     <= 1'b1;
        code_q   <= '0;
        ab_q     <= 1'b0;
        lc_q     <= 1'b0;
        tx_valid <= 1'b0;
        tx_last  <= 1'b0;
        idx      <= '0;
        st       <= S_STAT;
      end else begin
        case (st)
          S_IDLE: if (go && !hold) begin
            start_q <= start_ptr;
            end_q   <= end_ptr;
            cnt     <= '0;
            ab_q    <= 1'b0;
            lc_q    <= 1'b0;
            cn_q    <= 1'b0;
            code_q  <= '0;
            st      <= S_CTRL_RD;
          end
          S_CTRL_RD: st <= S_CTRL_CAP;
          S_CTRL_CAP: begin
            ctrl_q  <= mem_rdata;
            tx_ctrl <= mem_rdata[3:0];
            rd_ptr  <= start_q + AW'(1);
            st      <= S_FETCH;
          end
          S_FETCH: st <= S_LOAD;
          S_LOAD: begin
            tx_data  <= mem_rdata;
            tx_valid <= 1'b1;
            tx_last  <= (rd_ptr == end_q);
            st       <= S_SEND;
          end
          S_SEND: if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (tx_last) st <= S_RESULT;
            else begin
              rd_ptr <= rd_ptr + AW'(1);
              st     <= S_FETCH;
            end
          end
          S_RESULT: if (res_valid) begin
            ab_q   <= res_abort;
            lc_q   <= res_latecol;
            code_q <= res_code;
            idx    <= '0;
            st     <= S_STAT;
          end
          S_STAT: begin
            if (idx == IW'(STAT_BYTES - 1)) st <= S_FINISH;
            idx <= idx + IW'(1);
          end
          S_FINISH: begin
            tx_ctrl <= '0;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_txseq.sv
module pkt_txseq #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              end_wr,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic [ADDR_W-1:0] start_ptr,
  output logic [ADDR_W-1:0] end_ptr,
  input  logic              txrq_set,
  input  logic              txrq_clr,
  output logic              txrq,
  input  logic              txif_clr,
  input  logic              tx_ie,
  input  logic              glb_ie,
  output logic              txif,
  output logic              irq,
  output logic              tx_abort,
  output logic              tx_latecol,
  input  logic              dma_req,
  input  logic              dma_done,
  output logic              dma_busy,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [7:0]        dma_wdata,
  output logic [7:0]        dma_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [3:0]        tx_ctrl,
  input  logic              res_valid,
  input  logic              res_abort,
  input  logic              res_latecol,
  input  logic [7:0]        res_code
);
  logic              seq_we, seq_idle, seq_done, seq_abort, seq_late;
  logic [ADDR_W-1:0] seq_addr, ram_addr;
  logic [7:0]        seq_wdata, ram_wdata, ram_rdata;
  logic              ram_we;

  txseq_regs #(.AW(ADDR_W)) u_regs (
    .clk, .rst, .start_wr, .end_wr, .ptr_wdata, .txrq_set, .txrq_clr,
    .txif_clr, .tx_ie, .glb_ie, .seq_done, .seq_abort, .seq_late,
    .start_ptr, .end_ptr, .txrq, .txif, .irq, .tx_abort, .tx_latecol
  );

  txseq_arb #(.AW(ADDR_W)) u_arb (
    .clk, .rst, .dma_req, .dma_done, .txrq, .seq_idle,
    .dma_we, .dma_addr, .dma_wdata, .seq_we, .seq_addr, .seq_wdata,
    .dma_busy, .ram_we, .ram_addr, .ram_wdata
  );

  txseq_fsm #(.AW(ADDR_W), .CW(CNT_W)) u_fsm (
    .clk, .rst, .go(txrq && !txrq_clr), .hold(dma_busy), .cancel(txrq_clr),
    .start_ptr, .end_ptr, .mem_we(seq_we), .mem_addr(seq_addr),
    .mem_wdata(seq_wdata), .mem_rdata(ram_rdata),
    .tx_data, .tx_valid, .tx_ready, .tx_last, .tx_ctrl,
    .res_valid, .res_abort, .res_latecol, .res_code,
    .idle(seq_idle), .done(seq_done), .abort_o(seq_abort), .late_o(seq_late)
  );

  txseq_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk, .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign dma_rdata = ram_rdata;
endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              txrq,
  input logic              txrq_clr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              dma_busy,
  input logic              txif,
  input logic              txif_clr,
  input logic              irq,
  input logic              tx_ie,
  input logic              glb_ie,
  input logic              start_wr,
  input logic              end_wr,
  input logic [ADDR_W-1:0] start_ptr,
  input logic [ADDR_W-1:0] end_ptr
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !txrq_clr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R2

  AST_STREAM_NEEDS_RQ: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> txrq); // R7

  AST_DONE_DROPS_RQ: assert property (@(posedge clk) disable iff (rst)
    $rose(txif) |-> !txrq); // R5

  AST_TXIF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (txif && !txif_clr) |=> txif); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(txif && tx_ie && glb_ie)); // R6

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    dma_busy |-> !tx_valid); // R8

  AST_DMA_GRANT_NO_RQ: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_busy) |-> !$past(txrq)); // R9

  AST_PTR_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!start_wr && !end_wr) |=> ($stable(start_ptr) && $stable(end_ptr))); // R10
endmodule

bind pkt_txseq txseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .txrq(txrq), .txrq_clr(txrq_clr), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .dma_busy(dma_busy),
  .txif(txif), .txif_clr(txif_clr), .irq(irq), .tx_ie(tx_ie), .glb_ie(glb_ie),
  .start_wr(start_wr), .end_wr(end_wr), .start_ptr(start_ptr), .end_ptr(end_ptr)
);

// File: tb/pkt_txseq_tb.sv
module pkt_txseq_tb;
  localparam int AW = 11;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst = 1;
  logic start_wr = 0, end_wr = 0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [AW-1:0] start_ptr, end_ptr;
  logic txrq_set = 0, txrq_clr = 0, txrq;
  logic txif_clr = 0, tx_ie = 0, glb_ie = 0, txif, irq, tx_abort, tx_latecol;
  logic dma_req = 0, dma_done = 0, dma_busy, dma_we = 0;
  logic [AW-1:0] dma_addr = '0;
  logic [7:0] dma_wdata = '0, dma_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready = 0, tx_last;
  logic [3:0] tx_ctrl;
  logic res_valid = 0, res_abort = 0, res_latecol = 0;
  logic [7:0] res_code = '0;

  int checks = 0, fails = 0;

  pkt_txseq #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(logic [7:0] seed, int i);
    return seed + 8'(i * 13);
  endfunction

  task automatic dma_open();
    @(negedge clk); dma_req = 1;
    @(negedge clk); dma_req = 0;
    for (int k = 0; k < 100 && !dma_busy; k++) @(negedge clk);
  endtask

  task automatic dma_close();
    dma_we = 0; dma_done = 1;
    @(negedge clk); dma_done = 0;
  endtask

  task automatic dma_wr(logic [AW-1:0] a, logic [7:0] d);
    dma_we = 1; dma_addr = a; dma_wdata = d;
    @(negedge clk); dma_we = 0;
  endtask

  task automatic dma_rd(logic [AW-1:0] a, output logic [7:0] d);
    dma_we = 0; dma_addr = a;
    @(negedge clk); d = dma_rdata;
  endtask

  task automatic set_ptrs(logic [AW-1:0] s, logic [AW-1:0] e);
    @(negedge clk); start_wr = 1; ptr_wdata = s;
    @(negedge clk); start_wr = 0; end_wr = 1; ptr_wdata = e;
    @(negedge clk); end_wr = 0;
  endtask

  task automatic load_frame(logic [AW-1:0] s, int len, logic [7:0] ctrl, logic [7:0] seed);
    dma_open();
    dma_wr(s, ctrl);
    for (int i = 0; i < len; i++) dma_wr((s + AW'(1 + i)) & AMASK, pay(seed, i));
    dma_close();
    set_ptrs(s, (s + AW'(len)) & AMASK);
  endtask

  task automatic raise_rq();
    @(negedge clk); txrq_set = 1;
    @(negedge clk); txrq_set = 0;
  endtask

  // mode 0: always ready; mode 1: ready on two of every three cycles
  task automatic collect(string req, int len, logic [7:0] seed, logic [3:0] ctrl, int mode);
    int got = 0, bad = 0, lasts = 0, ctlbad = 0, cyc = 0;
    bit fin = 0;
    while (!fin && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      tx_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (tx_valid && tx_ready) begin
        if (tx_data !== pay(seed, got)) bad++;
        if (tx_ctrl !== ctrl) ctlbad++;
        if (tx_last) begin lasts++; fin = (got == len - 1); if (!fin) bad++; end
        got++;
        if (got >= len) fin = 1;
      end
    end
    @(negedge clk); tx_ready = 0;
    res_valid = 1;
    @(negedge clk); res_valid = 0;
    chk({req, " byte order/content"}, 32'(bad), 0);
    chk({req, " byte count"}, 32'(got), 32'(len));
    chk({"R2 last once ", req}, 32'(lasts), 1);
    chk({"R1 tx_ctrl ", req}, 32'(ctlbad), 0);
  endtask

  task automatic wait_txif();
    for (int k = 0; k < 100 && !txif; k++) @(negedge clk);
  endtask

  task automatic check_status(string req, logic [AW-1:0] e, logic [15:0] cnt,
                              logic [7:0] flg, logic [7:0] ctrl, logic [7:0] code,
                              logic [AW-1:0] s, bit open_done);
    logic [7:0] exp [7];
    logic [7:0] d;
    logic [15:0] sx;
    sx = 16'(s);
    exp[0] = cnt[7:0]; exp[1] = cnt[15:8]; exp[2] = flg; exp[3] = ctrl;
    exp[4] = code; exp[5] = sx[7:0]; exp[6] = sx[15:8];
    if (!open_done) dma_open();
    for (int i = 0; i < 7; i++) begin
      dma_rd((e + AW'(1 + i)) & AMASK, d);
      chk({req, " status byte"}, {24'(i), d}, {24'(i), exp[i]});
    end
    dma_close();
  endtask

  task automatic clear_flag();
    @(negedge clk); txif_clr = 1;
    @(negedge clk); txif_clr = 0;
  endtask

  task automatic t_reset();
    chk("R5 reset txrq", 32'(txrq), 0);
    chk("R6 reset txif", 32'(txif), 0);
    chk("R6 reset irq", 32'(irq), 0);
    chk("R2 reset tx_valid", 32'(tx_valid), 0);
    chk("R8 reset dma_busy", 32'(dma_busy), 0);
  endtask

  task automatic t_basic();
    tx_ie = 1; glb_ie = 1;
    load_frame(AW'(12'h120), 5, 8'h0E, 8'h30);
    raise_rq();
    collect("R1 R2 basic", 5, 8'h30, 4'hE, 0);
    wait_txif();
    chk("R5 txif set", 32'(txif), 1);
    chk("R5 txrq cleared", 32'(txrq), 0);
    chk("R5 tx_abort ok", 32'(tx_abort), 0);
    chk("R5 tx_latecol ok", 32'(tx_latecol), 0);
    @(negedge clk);
    chk("R6 irq enabled", 32'(irq), 1);
    chk("R10 start_ptr kept", 32'(start_ptr), 32'h120);
    chk("R10 end_ptr kept", 32'(end_ptr), 32'h125);
    check_status("R3 basic", AW'(12'h125), 16'd5, 8'h01, 8'h0E, 8'h5A, AW'(12'h120), 0);
    clear_flag();
  endtask

  task automatic t_backpressure();
    load_frame(AW'(12'h200), 9, 8'h03, 8'h91);
    res_code = 8'h11;
    raise_rq();
    collect("R2 backpressure", 9, 8'h91, 4'h3, 1);
    wait_txif();
    check_status("R3 backpressure", AW'(12'h209), 16'd9, 8'h01, 8'h03, 8'h11, AW'(12'h200), 0);
    clear_flag();
  endtask

  task automatic t_wrap();
    load_frame(AW'(11'h7FE), 3, 8'h05, 8'hC4);
    res_code = 8'h22;
    raise_rq();
    collect("R4 wrap", 3, 8'hC4, 4'h5, 0);
    wait_txif();
    check_status("R4 R3 wrap", AW'(11'h001), 16'd3, 8'h01, 8'h05, 8'h22, AW'(11'h7FE), 0);
    clear_flag();
  endtask

  task automatic t_mac_abort();
    load_frame(AW'(12'h300), 4, 8'h0F, 8'h10);
    res_code = 8'h7E; res_abort = 1; res_latecol = 1;
    raise_rq();
    collect("R5 mac abort", 4, 8'h10, 4'hF, 0);
    wait_txif();
    res_abort = 0; res_latecol = 0;
    chk("R5 tx_abort set", 32'(tx_abort), 1);
    chk("R5 tx_latecol set", 32'(tx_latecol), 1);
    chk("R5 txrq cleared on abort", 32'(txrq), 0);
    check_status("R3 abort", AW'(12'h304), 16'd4, 8'h06, 8'h0F, 8'h7E, AW'(12'h300), 0);
    clear_flag();
  endtask

  task automatic t_cancel();
    int got = 0;
    load_frame(AW'(12'h400), 8, 8'h01, 8'h55);
    res_code = 8'h99;
    raise_rq();
    for (int k = 0; k < 500 && got < 2; k++) begin
      @(negedge clk);
      tx_ready = 1;
      if (tx_valid) got++;
    end
    @(negedge clk); tx_ready = 0;
    repeat (4) @(negedge clk);
    chk("R7 valid before cancel", 32'(tx_valid), 1);
    txrq_clr = 1;
    @(negedge clk); txrq_clr = 0;
    chk("R7 valid dropped", 32'(tx_valid), 0);
    chk("R7 txrq cleared", 32'(txrq), 0);
    wait_txif();
    chk("R7 txif after cancel", 32'(txif), 1);
    chk("R7 tx_abort after cancel", 32'(tx_abort), 1);
    check_status("R7 cancel", AW'(12'h408), 16'd2, 8'h0A, 8'h01, 8'h00, AW'(12'h400), 0);
    clear_flag();
  endtask

  task automatic t_dma_holds_tx();
    int early = 0;
    load_frame(AW'(12'h500), 4, 8'h08, 8'h21);
    res_code = 8'h33;
    dma_open();
    raise_rq();
    tx_ready = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (tx_valid) early++;
    end
    tx_ready = 0;
    chk("R8 no stream during DMA", 32'(early), 0);
    chk("R8 txrq still set", 32'(txrq), 1);
    dma_close();
    collect("R8 after DMA", 4, 8'h21, 4'h8, 0);
    wait_txif();
    check_status("R8 status", AW'(12'h504), 16'd4, 8'h01, 8'h08, 8'h33, AW'(12'h500), 0);
    clear_flag();
  endtask

  task automatic t_dma_held();
    int granted = 0;
    load_frame(AW'(12'h600), 3, 8'h02, 8'h44);
    res_code = 8'h44;
    raise_rq();
    @(negedge clk); dma_req = 1;
    @(negedge clk); dma_req = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dma_busy) granted++;
    end
    chk("R9 DMA held while txrq", 32'(granted), 0);
    collect("R9 frame", 3, 8'h44, 4'h2, 0);
    wait_txif();
    for (int k = 0; k < 10 && !dma_busy; k++) @(negedge clk);
    chk("R9 DMA granted after close", 32'(dma_busy), 1);
    check_status("R9 status", AW'(12'h603), 16'd3, 8'h01, 8'h02, 8'h44, AW'(12'h600), 1);
    clear_flag();
  endtask

  task automatic t_irq();
    load_frame(AW'(12'h700), 1, 8'h00, 8'h66);
    raise_rq();
    collect("R6 single", 1, 8'h66, 4'h0, 0);
    wait_txif();
    @(negedge clk); glb_ie = 0;
    repeat (3) @(negedge clk);
    chk("R6 irq off without global enable", 32'(irq), 0);
    chk("R6 txif sticky", 32'(txif), 1);
    glb_ie = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 irq with enables", 32'(irq), 1);
    clear_flag();
    chk("R6 txif cleared", 32'(txif), 0);
    @(negedge clk);
    chk("R6 irq follows clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    res_code = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_wrap();
    t_mac_abort();
    t_cancel();
    t_dma_holds_tx();
    t_dma_held();
    t_irq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule